// File: doc/BRIEF.md
# Banked Interrupt Enable and Status Controller

This block keeps one interrupt-enable register and one interrupt-status register for each locality of a multi-locality device, and it drives a single shared interrupt line. An event source reports an event by pulsing a valid strobe with a locality tag and a four-bit kind vector (data available, status valid, locality changed, command ready). Each kind sets its own status bit, but only in the tagged locality, and only when that locality has its global enable and that kind's enable bit set.

Software reaches the registers through a small select-based port. A locality number and a register select pick the enable, vector or status register, and writes carry byte enables. Only the locality that currently owns the device can change its enable or status registers. Any locality can be read. The status register is write-one-to-clear. The shared line is a level that stays high until a clearing write empties the status of the locality that wrote it. The vector register returns a fixed value given as a parameter.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every locality's enable register reads 0x0000_0008 (polarity field bits 4:3 = 2'b01, low level), every status register reads 0, and irqOut is 0.
- R2: An event whose locality is at most NUM_LOC-1 sets status bit 0 for evtKind[0] (data available), bit 1 for evtKind[1] (status valid), bit 2 for evtKind[2] (locality changed) and bit 7 for evtKind[3] (command ready). A bit is set only when enable bit 31 (global) and the enable bit at the same position are both 1. When any bit is set, irqOut goes to 1 on the same clock edge.
- R3: An event with a locality tag above NUM_LOC-1, or with its global or own enable bit clear, changes no status register and does not raise irqOut.
- R4: Writing the status register (regSel = 2) clears each status bit written as 1 in an enabled byte lane. Bits other than 0, 1, 2 and 7 are never set.
- R5: irqOut drops to 0 only when a status write clears at least one set bit and leaves that locality's status at zero. A write that leaves any bit set keeps irqOut at 1.
- R6: Writes to the enable or status register are ignored unless activeValid is 1 and regLoc equals activeLoc.
- R7: A write to the enable register (regSel = 0) updates only the bytes whose wrBe bit is 1. Within those bytes only bits 31, 7, 4:3 and 2:0 take the written value, and every other bit reads 0.
- R8: The vector register (regSel = 1) always reads the IRQ_VEC parameter, and writes to it have no effect.
- R9: Once high, irqOut stays high without further events until a clearing write lowers it.
- R10: When an event and a clearing status write hit the same locality in the same cycle, the event's bits are set after the clear and irqOut stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| activeValid | input | 1 | A locality currently owns the device |
| activeLoc | input | LOC_W | Index of the owning locality |
| evtValid | input | 1 | Event strobe |
| evtLoc | input | LOC_W | Locality tag of the event |
| evtKind | input | 4 | Event kinds: [0] data avail, [1] status valid, [2] locality change, [3] command ready |
| regLoc | input | LOC_W | Locality addressed by the register port |
| regSel | input | 2 | 0 enable, 1 vector, 2 status, 3 reserved (reads 0) |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| wrBe | input | 4 | Byte enables for the write |
| rdData | output | 32 | Combinational read data for regLoc/regSel |
| irqOut | output | 1 | Shared interrupt level |

## Verification
On every cycle the assertions check several properties. Reserved enable bits and unsupported status bits stay zero. A write from a non-owning locality leaves all banked registers unchanged. An event tagged with an invalid locality changes no status. The line can rise only after an event and can fall only after a status write. The directed scenarios cover what needs a specific sequence of steps: the byte-lane masking of enable writes, per-bit event gating, clearing bits one at a time while the line is held, the same-cycle race between a set and a clear, and the fixed vector value.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;
  localparam int DW = 32;
  localparam int GLOBAL_BIT = 31;
  localparam int BIT_DAVAIL = 0;
  localparam int BIT_STSVAL = 1;
  localparam int BIT_LOCCHG = 2;
  localparam int BIT_CMDRDY = 7;
  localparam logic [DW-1:0] INT_MASK =
    (32'd1 << BIT_DAVAIL) | (32'd1 << BIT_STSVAL) | (32'd1 << BIT_LOCCHG) | (32'd1 << BIT_CMDRDY);
  localparam logic [DW-1:0] POL_MASK = 32'h0000_0018;
  localparam logic [DW-1:0] EN_WR_MASK = (32'd1 << GLOBAL_BIT) | POL_MASK | INT_MASK;
  localparam logic [DW-1:0] EN_RESET = 32'h0000_0008;

  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_VEC = 2'd1,
    SEL_STS = 2'd2,
    SEL_RSV = 2'd3
  } regSel_e;

  typedef struct packed {
    logic          enWr;
    logic          stsClr;
    logic          evtSet;
    logic [DW-1:0] laneMask;
    logic [DW-1:0] setBits;
  } strobe_t;
endpackage

// File: rtl/loc_irq_ctrl_unit.sv
module loc_irq_ctrl_unit
  import loc_irq_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3
) (
  input  logic             activeValid,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             evtValid,
  input  logic [LOC_W-1:0] evtLoc,
  input  logic [3:0]       evtKind,
  input  logic [LOC_W-1:0] regLoc,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [3:0]       wrBe,
  output strobe_t          stb
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  logic ownerWr;

  assign ownerWr = wrEn && activeValid && (regLoc == activeLoc) && (regLoc <= LAST_LOC);

  always_comb begin
    stb = '0;
    stb.enWr   = ownerWr && (regSel == SEL_EN);
    stb.stsClr = ownerWr && (regSel == SEL_STS);
    stb.evtSet = evtValid && (evtLoc <= LAST_LOC);
    for (int b = 0; b < 4; b++) begin
      stb.laneMask[8*b +: 8] = {8{wrBe[b]}};
    end
    stb.setBits[BIT_DAVAIL] = evtKind[0];
    stb.setBits[BIT_STSVAL] = evtKind[1];
    stb.setBits[BIT_LOCCHG] = evtKind[2];
    stb.setBits[BIT_CMDRDY] = evtKind[3];
  end
endmodule

// File: rtl/loc_irq_datapath.sv
module loc_irq_datapath
  import loc_irq_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [LOC_W-1:0]      wrLoc,
  input  logic [LOC_W-1:0]      evtLoc,
  input  logic [DW-1:0]         wrData,
  output logic [NUM_LOC*DW-1:0] enFlat,
  output logic [NUM_LOC*DW-1:0] stsFlat,
  output logic                  irqOut
);
  logic [NUM_LOC-1:0] anySet;
  logic [NUM_LOC-1:0] lowerReq;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_bank
    logic [DW-1:0] enQ, stsQ, setHere, clrHere, stsNext;

    always_comb begin
      setHere = '0;
      if (stb.evtSet && evtLoc == LOC_W'(i) && enQ[GLOBAL_BIT]) setHere = stb.setBits & enQ;
      clrHere = '0;
      if (stb.stsClr && wrLoc == LOC_W'(i)) clrHere = wrData & stb.laneMask & INT_MASK;
      stsNext = (stsQ & ~clrHere) | setHere;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ  <= EN_RESET;
        stsQ <= '0;
      end else begin
        if (stb.enWr && wrLoc == LOC_W'(i))
          enQ <= (enQ & ~stb.laneMask) | (wrData & stb.laneMask & EN_WR_MASK);
        stsQ <= stsNext;
      end
    end

    assign anySet[i]   = |setHere;
    assign lowerReq[i] = (|clrHere) && (|stsQ) && (stsNext == '0);
    assign enFlat[i*DW +: DW]  = enQ;
    assign stsFlat[i*DW +: DW] = stsQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else if (|anySet) irqOut <= 1'b1;
    else if (|lowerReq) irqOut <= 1'b0;
  end
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import loc_irq_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3,
  parameter logic [31:0] IRQ_VEC = 32'h0000_000A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             activeValid,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             evtValid,
  input  logic [LOC_W-1:0] evtLoc,
  input  logic [3:0]       evtKind,
  input  logic [LOC_W-1:0] regLoc,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  input  logic [3:0]       wrBe,
  output logic [31:0]      rdData,
  output logic             irqOut
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  strobe_t stb;
  logic [NUM_LOC*DW-1:0] enFlat;
  logic [NUM_LOC*DW-1:0] stsFlat;

  loc_irq_ctrl_unit #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_ctrl (
    .activeValid(activeValid), .activeLoc(activeLoc),
    .evtValid(evtValid), .evtLoc(evtLoc), .evtKind(evtKind),
    .regLoc(regLoc), .regSel(regSel), .wrEn(wrEn), .wrBe(wrBe),
    .stb(stb)
  );

  loc_irq_datapath #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrLoc(regLoc), .evtLoc(evtLoc),
    .wrData(wrData), .enFlat(enFlat), .stsFlat(stsFlat), .irqOut(irqOut)
  );

  always_comb begin
    rdData = '0;
    if (regSel == SEL_VEC) rdData = IRQ_VEC;
    else if (regLoc <= LAST_LOC) begin
      if (regSel == SEL_EN) rdData = enFlat[DW*int'(regLoc) +: DW];
      else if (regSel == SEL_STS) rdData = stsFlat[DW*int'(regLoc) +: DW];
    end
  end
endmodule

// File: rtl/loc_irq_ctrl_chk.sv
module loc_irq_ctrl_chk
  import loc_irq_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  activeValid,
  input logic [LOC_W-1:0]      activeLoc,
  input logic                  evtValid,
  input logic [LOC_W-1:0]      evtLoc,
  input logic [LOC_W-1:0]      regLoc,
  input logic [1:0]            regSel,
  input logic                  wrEn,
  input logic                  irqOut,
  input logic [NUM_LOC*DW-1:0] enFlat,
  input logic [NUM_LOC*DW-1:0] stsFlat
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  a_r7_en_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (enFlat & {NUM_LOC{~EN_WR_MASK}}) == '0);

  a_r4_sts_supported_only: assert property (@(posedge clk) disable iff (!rstN)
    (stsFlat & {NUM_LOC{~INT_MASK}}) == '0);

  a_r6_nonowner_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(activeValid && regLoc == activeLoc) && !evtValid)
    |=> ($stable(enFlat) && $stable(stsFlat)));

  a_r3_invalid_loc_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtLoc > LAST_LOC && !wrEn) |=> $stable(stsFlat));

  a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(evtValid));

  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(wrEn && regSel == SEL_STS));
endmodule

bind loc_irq_ctrl loc_irq_ctrl_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rstN(rstN), .activeValid(activeValid), .activeLoc(activeLoc),
  .evtValid(evtValid), .evtLoc(evtLoc), .regLoc(regLoc), .regSel(regSel),
  .wrEn(wrEn), .irqOut(irqOut), .enFlat(enFlat), .stsFlat(stsFlat)
);

// File: tb/sim_loc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_loc_irq_ctrl;
  localparam int NUM_LOC = 5;
  localparam int LOC_W = 3;
  localparam logic [31:0] VEC = 32'h0000_000A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic activeValid = 1'b0;
  logic [LOC_W-1:0] activeLoc = '0;
  logic evtValid = 1'b0;
  logic [LOC_W-1:0] evtLoc = '0;
  logic [3:0] evtKind = '0;
  logic [LOC_W-1:0] regLoc = '0;
  logic [1:0] regSel = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0] wrBe = '0;
  logic [31:0] rdData;
  logic irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  loc_irq_ctrl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_VEC(VEC)) u0 (
    .clk(clk), .rstN(rstN), .activeValid(activeValid), .activeLoc(activeLoc),
    .evtValid(evtValid), .evtLoc(evtLoc), .evtKind(evtKind),
    .regLoc(regLoc), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .wrBe(wrBe), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one clock with optional write and event, inputs changed at the falling edge
  task automatic step(input bit w, input logic [2:0] wl, input logic [1:0] ws,
                      input logic [31:0] wd, input logic [3:0] be,
                      input bit e, input logic [2:0] el, input logic [3:0] ek);
    @(negedge clk);
    wrEn = w; regLoc = wl; regSel = ws; wrData = wd; wrBe = be;
    evtValid = e; evtLoc = el; evtKind = ek;
    @(negedge clk);
    wrEn = 0; evtValid = 0;
  endtask

  task automatic wr(input logic [2:0] l, input logic [1:0] s, input logic [31:0] d, input logic [3:0] be);
    step(1, l, s, d, be, 0, 0, 0);
  endtask

  task automatic evt(input logic [2:0] l, input logic [3:0] k);
    step(0, 0, 0, 0, 0, 1, l, k);
  endtask

  task automatic rd(input logic [2:0] l, input logic [1:0] s, output logic [31:0] v);
    regLoc = l; regSel = s; #1; v = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < NUM_LOC; i++) begin
      rd(i[2:0], 2'd0, v); check("R1 enable reset", v, 32'h8);
      rd(i[2:0], 2'd2, v); check("R1 status reset", v, 32'h0);
    end
    check("R1 irq reset", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    rd(0, 2'd1, v); check("R8 vector read", v, VEC);
    activeValid = 1; activeLoc = 0;
    wr(0, 2'd1, 32'hFFFF_FFFF, 4'hF);
    rd(0, 2'd1, v); check("R8 vector write ignored", v, VEC);
    rd(0, 2'd0, v); check("R8 enable untouched", v, 32'h8);
  endtask

  task automatic t_enable_write();
    logic [31:0] v;
    activeValid = 1; activeLoc = 2;
    wr(2, 2'd0, 32'hFFFF_FFFF, 4'hF);
    rd(2, 2'd0, v); check("R7 writable bits", v, 32'h8000_009F);
    wr(2, 2'd0, 32'h0000_0000, 4'b1000);
    rd(2, 2'd0, v); check("R7 upper lane only", v, 32'h0000_009F);
    wr(2, 2'd0, 32'hFFFF_FF00, 4'b1000);
    rd(2, 2'd0, v); check("R7 lane restore", v, 32'h8000_009F);
  endtask

  task automatic t_events_and_clear();
    logic [31:0] v;
    evt(2, 4'b0001);
    rd(2, 2'd2, v); check("R2 data-avail bit", v, 32'h01);
    check("R2 irq raised", {31'd0, irqOut}, 32'd1);
    repeat (5) @(negedge clk);
    check("R9 irq held", {31'd0, irqOut}, 32'd1);
    evt(2, 4'b1000);
    rd(2, 2'd2, v); check("R2 cmd-ready bit 7", v, 32'h81);
    wr(2, 2'd2, 32'h0000_007E, 4'hF);
    rd(2, 2'd2, v); check("R4 clear of unset bits", v, 32'h81);
    check("R5 irq still high", {31'd0, irqOut}, 32'd1);
    wr(2, 2'd2, 32'h0000_0001, 4'hF);
    rd(2, 2'd2, v); check("R4 w1c one bit", v, 32'h80);
    check("R5 irq kept with bit left", {31'd0, irqOut}, 32'd1);
    wr(2, 2'd2, 32'h0000_0080, 4'b1110);
    rd(2, 2'd2, v); check("R4 disabled lane no clear", v, 32'h80);
    wr(2, 2'd2, 32'h0000_0080, 4'b0001);
    rd(2, 2'd2, v); check("R4 last bit cleared", v, 32'h0);
    check("R5 irq lowered", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_non_owner();
    logic [31:0] v;
    wr(1, 2'd0, 32'hFFFF_FFFF, 4'hF);
    rd(1, 2'd0, v); check("R6 non-owner enable", v, 32'h8);
    evt(2, 4'b0010);
    activeLoc = 3;
    wr(2, 2'd2, 32'hFFFF_FFFF, 4'hF);
    rd(2, 2'd2, v); check("R6 non-owner status", v, 32'h02);
    check("R6 irq unchanged", {31'd0, irqOut}, 32'd1);
    activeValid = 0; activeLoc = 2;
    wr(2, 2'd2, 32'hFFFF_FFFF, 4'hF);
    rd(2, 2'd2, v); check("R6 no owner status", v, 32'h02);
    activeValid = 1;
    wr(2, 2'd2, 32'h02, 4'hF);
    rd(2, 2'd2, v); check("R6 owner clears", v, 32'h0);
    check("R5 irq low after owner clear", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_gating();
    logic [31:0] v;
    evt(6, 4'hF);
    for (int i = 0; i < NUM_LOC; i++) begin
      rd(i[2:0], 2'd2, v); check("R3 invalid locality", v, 32'h0);
    end
    check("R3 irq after invalid", {31'd0, irqOut}, 32'd0);
    wr(2, 2'd0, 32'h0000_009F, 4'hF);
    evt(2, 4'hF);
    rd(2, 2'd2, v); check("R3 global off", v, 32'h0);
    check("R3 irq global off", {31'd0, irqOut}, 32'd0);
    wr(2, 2'd0, 32'h8000_0001, 4'hF);
    evt(2, 4'b0110);
    rd(2, 2'd2, v); check("R3 own enable off", v, 32'h0);
    evt(2, 4'b0111);
    rd(2, 2'd2, v); check("R2 per-bit gating", v, 32'h01);
    check("R2 irq on gated event", {31'd0, irqOut}, 32'd1);
  endtask

  task automatic t_race();
    logic [31:0] v;
    step(1, 2, 2'd2, 32'h01, 4'hF, 1, 2, 4'b0001);
    rd(2, 2'd2, v); check("R10 set wins over clear", v, 32'h01);
    check("R10 irq stays", {31'd0, irqOut}, 32'd1);
    wr(2, 2'd2, 32'h01, 4'hF);
    check("R10 later clear lowers", {31'd0, irqOut}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_enable_write();
    t_events_and_clear();
    t_non_owner();
    t_gating();
    t_race();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule